// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM from reset to a usable state. It owns the command pins (chip select, row strobe, column strobe, write enable), the address lines and the bank-select lines for the whole bring-up. During that time it steps through a fixed order of commands, and every step is followed by a wait whose length is a parameter in clock cycles.

The order is as follows. First the block holds NOP for a stabilization period. It then precharges every bank, with the A10 address line high. Next come two auto-refresh commands, and last a mode-register load. The mode word comes from a configuration input.

The mode word is cleaned before it reaches the address lines. The reserved bits and the operating-mode bits are driven to zero. If the word asks for a CAS latency or a burst length that the memory does not support, the block loads a safe setting instead, CAS latency 3 and burst length 1, and raises a sticky configuration-error flag. After the final wait the done flag rises. From then on the bus shows NOP until the next reset, and a memory controller can take over.

All outputs are registered. The block has no data stream, so every pin is plain control or status and none uses back-pressure.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the command pins {cs_n,ras_n,cas_n,we_n} read 0111 (NOP), the address and bank lines are 0, and init_done and cfg_err are 0.
- R2: After reset is released the bus shows NOP for exactly T_STABLE cycles. In the next cycle it shows one PRECHARGE (0010) with address bit 10 at 1, all other address bits at 0 and the bank lines at 0.
- R3: After the precharge come exactly T_RP NOP cycles, then one AUTO REFRESH (0001) with the address at 0.
- R4: Each auto refresh is followed by exactly T_RFC NOP cycles. Exactly two refreshes are issued, and the second wait is followed by LOAD MODE (0000).
- R5: During LOAD MODE the address carries the cfg_mode fields in place: burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4 and write-burst mode in bit 9. Bits 8:7, bits 11:10, any higher address bits and the bank lines are 0.
- R6: A mode word is treated as reserved if its CAS latency field is anything other than 010 or 011, or its burst length is 100, 110 or 101, or its burst length is 111 with burst type 1. For such a word the loaded CAS latency is 011 and the loaded burst length is 000, the other fields follow R5, and cfg_err is 1 from the LOAD MODE cycle until reset.
- R7: A mode word that is not reserved leaves cfg_err at 0 for the whole sequence.
- R8: After LOAD MODE come exactly T_MRD NOP cycles. init_done then rises and stays at 1 until reset, and the bus shows NOP with the address at 0 while init_done is 1.
- R9: A reset asserted at any point of the sequence returns the outputs to the R1 state. The whole sequence then restarts with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 12 | Requested mode word; sampled in the LOAD MODE cycle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W | Address lines (A10 = precharge-all, low 12 bits = mode word) |
| cmd_ba | output | BA_W | Bank-select lines |
| init_done | output | 1 | High once the sequence is complete, until reset |
| cfg_err | output | 1 | Sticky flag: the requested mode word was reserved and was replaced |

## Verification
The block has only one internal state and one shared counter. A wrong state or a wrong counter value shows up at the pins as a command issued in the wrong cycle, a missing command or an extra command. The reference model predicts the exact cycle of every command, so such a fault is reported in the first cycle where the bus differs, which is at most one wait period after the fault. A sanitizer fault only shows during the single LOAD MODE cycle and on cfg_err. For that reason the bench runs several mode words: valid ones, a word with every reserved bit set, and words with reserved latency or burst codes.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  localparam int MODE_W = 12;

  typedef logic [3:0] cmd_t;  // {cs_n, ras_n, cas_n, we_n}

  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_REF = 4'b0001;
  localparam cmd_t CMD_LMR = 4'b0000;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_PRE,
    ST_WRP,
    ST_REF1,
    ST_WRFC1,
    ST_REF2,
    ST_WRFC2,
    ST_LMR,
    ST_WMRD,
    ST_DONE
  } state_t;

endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int          CNT_W = 8,
  parameter int unsigned INIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= CNT_W'(INIT);
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R2: while counting down, the count never falls by more than one per cycle
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pwrup_mode_sanitize.sv
module pwrup_mode_sanitize
  import pwrup_pkg::*;
(
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] mode_out,
  output logic              mode_bad
);

  logic [2:0] bl_f;
  logic       bt_f;
  logic [2:0] cl_f;
  logic       wb_f;
  logic       cl_bad;
  logic       bl_bad;

  always_comb begin
    bl_f = mode_in[2:0];
    bt_f = mode_in[3];
    cl_f = mode_in[6:4];
    wb_f = mode_in[9];

    cl_bad = !(cl_f == 3'd2 || cl_f == 3'd3);
    unique case (bl_f)
      3'd0, 3'd1, 3'd2, 3'd3: bl_bad = 1'b0;
      3'd7:                   bl_bad = bt_f;  // full page only in sequential order
      default:                bl_bad = 1'b1;
    endcase

    mode_bad = cl_bad || bl_bad;

    // substitute safe fields for a reserved request
    if (mode_bad) begin
      cl_f = 3'd3;
      bl_f = 3'd0;
    end

    mode_out = {2'b00, wb_f, 2'b00, cl_f, bt_f, bl_f};
  end

endmodule

// File: rtl/pwrup_cmd_reg.sv
module pwrup_cmd_reg
  import pwrup_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_t            state_d,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              mode_bad,
  output cmd_t              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              done,
  output logic              err
);

  localparam int PRE_ALL_BIT = 10;

  cmd_t              cmd_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    unique case (state_d)
      ST_PRE: begin
        cmd_d               = CMD_PRE;
        addr_d[PRE_ALL_BIT] = 1'b1;
      end
      ST_REF1, ST_REF2: cmd_d = CMD_REF;
      ST_LMR: begin
        cmd_d                = CMD_LMR;
        addr_d[MODE_W-1:0]   = mode_word;
      end
      default: cmd_d = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      cmd  <= cmd_d;
      addr <= addr_d;
      ba   <= '0;
      done <= (state_d == ST_DONE);
      if (state_d == ST_LMR && mode_bad) err <= 1'b1;
    end
  end

  // R8: once done, only NOP with a quiet address bus
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd == CMD_NOP && addr == '0));

  // R8: done never falls without reset
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R6: error flag is sticky
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R2: precharge always targets all banks
  assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (addr[PRE_ALL_BIT] && ba == '0));

  // R5: reserved and operating-mode bits are zero in the loaded word
  assert_mode_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (addr[11:10] == 2'b00 && addr[8:7] == 2'b00));

  // R6: the loaded CAS latency is always a supported one
  assert_mode_cl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (addr[6:4] == 3'd2 || addr[6:4] == 3'd3));

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import pwrup_pkg::*;
#(
  parameter int T_STABLE = 5000,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2,
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BA_W-1:0]   cmd_ba,
  output logic              init_done,
  output logic              cfg_err
);

  localparam int T_MAX1 = (T_STABLE > T_RP)  ? T_STABLE : T_RP;
  localparam int T_MAX2 = (T_RFC   > T_MRD) ? T_RFC    : T_MRD;
  localparam int T_MAX  = (T_MAX1  > T_MAX2) ? T_MAX1  : T_MAX2;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  state_t            state_q;
  state_t            state_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic [MODE_W-1:0] mode_clean;
  logic              mode_bad;
  cmd_t              cmd;

  pwrup_timer #(
    .CNT_W (CNT_W),
    .INIT  (T_STABLE - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  pwrup_mode_sanitize u_sanitize (
    .mode_in  (cfg_mode),
    .mode_out (mode_clean),
    .mode_bad (mode_bad)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_WAIT:  if (tmr_zero) state_d = ST_PRE;
      ST_PRE: begin
        state_d  = ST_WRP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RP - 1);
      end
      ST_WRP:   if (tmr_zero) state_d = ST_REF1;
      ST_REF1: begin
        state_d  = ST_WRFC1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RFC - 1);
      end
      ST_WRFC1: if (tmr_zero) state_d = ST_REF2;
      ST_REF2: begin
        state_d  = ST_WRFC2;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RFC - 1);
      end
      ST_WRFC2: if (tmr_zero) state_d = ST_LMR;
      ST_LMR: begin
        state_d  = ST_WMRD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_MRD - 1);
      end
      ST_WMRD:  if (tmr_zero) state_d = ST_DONE;
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  pwrup_cmd_reg #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d   (state_d),
    .mode_word (mode_clean),
    .mode_bad  (mode_bad),
    .cmd       (cmd),
    .addr      (cmd_addr),
    .ba        (cmd_ba),
    .done      (init_done),
    .err       (cfg_err)
  );

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;

  // refresh bookkeeping for the ordering checks below
  logic [1:0] ref_seen;
  logic       pre_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_seen <= '0;
      pre_seen <= 1'b0;
    end else begin
      if (cmd == CMD_REF && ref_seen != 2'd3) ref_seen <= ref_seen + 1'b1;
      if (cmd == CMD_PRE) pre_seen <= 1'b1;
    end
  end

  // R4: the mode load follows exactly two refreshes
  assert_two_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (ref_seen == 2'd2));

  // R4: never a third refresh
  assert_no_extra_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> (ref_seen < 2'd2));

  // R3: refreshes only after the precharge-all
  assert_ref_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> pre_seen);

  // R2: the precharge is issued once
  assert_single_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> !pre_seen);

  // R8: the cycle after the mode load is a NOP and done is still low
  assert_mrd_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |=> (cmd == CMD_NOP && !init_done));

endmodule

// File: tb/sim_sdram_powerup_seq.sv
module sim_sdram_powerup_seq;

  localparam int TS   = 40;
  localparam int TRP  = 3;
  localparam int TRFC = 7;
  localparam int TMRD = 2;
  localparam int AW   = 12;
  localparam int BW   = 2;

  localparam int P_PRE  = TS;
  localparam int P_REF1 = P_PRE + 1 + TRP;
  localparam int P_REF2 = P_REF1 + 1 + TRFC;
  localparam int P_LMR  = P_REF2 + 1 + TRFC;
  localparam int P_DONE = P_LMR + 1 + TMRD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   cfg_mode = 12'h000;
  logic          cs_n, ras_n, cas_n, we_n;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  logic          done, err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sdram_powerup_seq #(
    .T_STABLE (TS),
    .T_RP     (TRP),
    .T_RFC    (TRFC),
    .T_MRD    (TMRD),
    .ADDR_W   (AW),
    .BA_W     (BW)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cmd_cs_n  (cs_n),
    .cmd_ras_n (ras_n),
    .cmd_cas_n (cas_n),
    .cmd_we_n  (we_n),
    .cmd_addr  (addr),
    .cmd_ba    (ba),
    .init_done (done),
    .cfg_err   (err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_reserved(input logic [11:0] w);
    int cl = int'(w[6:4]);
    int bl = int'(w[2:0]);
    if (cl != 2 && cl != 3) return 1'b1;
    if (bl >= 4 && bl <= 6) return 1'b1;
    if (bl == 7 && w[3]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [11:0] loaded_word(input logic [11:0] w);
    logic [11:0] r = 12'h000;
    r[9] = w[9];
    r[3] = w[3];
    if (is_reserved(w)) begin
      r[6:4] = 3'b011;
      r[2:0] = 3'b000;
    end else begin
      r[6:4] = w[6:4];
      r[2:0] = w[2:0];
    end
    return r;
  endfunction

  // compare the bus against the expected picture at cycle index n after reset release
  task automatic compare_at(input int n, input logic [11:0] w);
    logic [3:0]    exp_cmd = 4'b0111;
    logic [AW-1:0] exp_addr = '0;
    logic          exp_done = (n >= P_DONE);
    logic          exp_err = (n >= P_LMR) && is_reserved(w);
    string         tag;
    if (n == 0)           tag = "R1";
    else if (n <= P_PRE)  tag = "R2";
    else if (n <= P_REF1) tag = "R3";
    else if (n < P_LMR)   tag = "R4";
    else if (n == P_LMR)  tag = is_reserved(w) ? "R6" : "R5";
    else                  tag = "R8";
    if (n == P_PRE) begin
      exp_cmd = 4'b0010;
      exp_addr[10] = 1'b1;
    end else if (n == P_REF1 || n == P_REF2) begin
      exp_cmd = 4'b0001;
    end else if (n == P_LMR) begin
      exp_cmd = 4'b0000;
      exp_addr[11:0] = loaded_word(w);
    end
    chk({cs_n, ras_n, cas_n, we_n} == exp_cmd, {tag, " cmd"},
        32'({cs_n, ras_n, cas_n, we_n}), 32'(exp_cmd));
    chk(addr == exp_addr, {tag, " addr"}, 32'(addr), 32'(exp_addr));
    chk(ba == '0, {tag, " ba"}, 32'(ba), 32'd0);
    chk(done == exp_done, {tag, " done"}, 32'(done), 32'(exp_done));
    chk(err == exp_err, is_reserved(w) ? "R6 err" : "R7 err", 32'(err), 32'(exp_err));
  endtask

  task automatic check_reset_state(input string tag);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, {tag, " reset cmd"},
        32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
    chk(addr == '0 && ba == '0, {tag, " reset addr/ba"}, 32'({addr, ba}), 32'd0);
    chk(!done && !err, {tag, " reset flags"}, 32'({done, err}), 32'd0);
  endtask

  // run the sequence with mode word w; stop_at >= 0 aborts with a reset at that index
  task automatic run_seq(input logic [11:0] w, input int stop_at);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_mode = w;
    repeat (2) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    for (int n = 0; n <= P_DONE + 6; n++) begin
      if (n > 0) @(negedge clk);
      compare_at(n, w);
      if (stop_at >= 0 && n == stop_at) begin
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R9");
        return;
      end
    end
  endtask

  initial begin
    // valid: CL 2, BL 4, sequential
    run_seq(12'h022, -1);
    // valid full page sequential, write-burst single, with reserved/opmode bits set (R5)
    run_seq(12'hFB7, -1);
    // reserved CAS latency 1 (R6)
    run_seq(12'h012, -1);
    // full page interleaved is reserved (R6)
    run_seq(12'h03F, -1);
    // burst length code 100 reserved, CL 2 (R6)
    run_seq(12'h224, -1);
    // valid interleaved BL 8 CL 3 (R7)
    run_seq(12'h03B, -1);
    // R9: reset in the middle of the refresh waits, then during the final wait
    run_seq(12'h012, P_REF1 + 2);
    run_seq(12'h022, -1);
    run_seq(12'h022, P_LMR + 1);
    run_seq(12'h032, -1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule